// File: doc/BRIEF.md
# External Interrupt Request Capture

This block turns two active-low external interrupt pins into request flags for a microcontroller-style interrupt controller. Each pin first crosses a two-flop synchronizer and is then sampled only when the machine-cycle strobe is high, so the sampling rate follows the processor's machine cycle rather than the raw clock. A mode bit for each pin picks how that pin raises its request. In edge mode a falling transition between two consecutive samples latches the flag. In level mode the flag tracks the most recent sample of the pin.

The interrupt controller sends a one-cycle acknowledge for each pin on vector entry. That acknowledge clears an edge-mode flag and leaves a level-mode flag alone, so a pin still held low keeps requesting. Software can set or clear any flag directly through write strobes, which lets code raise an interrupt by itself. All flags come from registers and reset synchronously.

Top module: `ext_irq_capture`

## Requirements
- R1: A pin is sampled only in a clock cycle where `mcyc_stb` is 1. A pin change that is never seen by a strobe sample does not change `req`.
- R2: In edge mode (`mode_edge[i]`=1), a sample of 1 followed by a sample of 0 on the next strobe sets `req[i]` after that strobe's clock edge.
- R3: In edge mode, `ack[i]`=1 clears `req[i]` on the next clock edge. A hardware edge or a `sw_set[i]` in the same cycle takes precedence over the acknowledge.
- R4: In level mode (`mode_edge[i]`=0), each strobe loads `req[i]` with the inverse of the synchronized pin, so a low pin gives 1. `ack[i]` has no effect on `req[i]`.
- R5: In level mode, a pin still held low after its acknowledge keeps `req[i]` at 1 through later strobes.
- R6: Each pin follows its own mode bit, independent of the other pin.
- R7: `sw_set[i]`=1 sets `req[i]` and `sw_clr[i]`=1 clears it on the next edge. If both are 1, the set wins. In level mode a strobe in the same cycle overrides both.
- R8: In edge mode, a detected falling edge sets `req[i]` even when `sw_clr[i]` is 1 in the same cycle.
- R9: After reset `req` is 0 and the stored previous sample is 1. A pin that stays high after reset raises no request.
- R10: A pin level reaches the sampler two clocks after it appears at `pin_n`. With a strobe on every clock, a fall sets `req` at the third rising edge after the change.
- R11: A low pulse that is gone before any strobe samples it through the synchronizer leaves `req` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | NUM_PINS | Asynchronous active-low interrupt pins |
| mcyc_stb | input | 1 | Machine-cycle sample strobe |
| mode_edge | input | NUM_PINS | Per pin: 1 = edge mode, 0 = level mode |
| ack | input | NUM_PINS | Per-pin acknowledge pulse on vector entry |
| sw_set | input | NUM_PINS | Software write that sets the flag |
| sw_clr | input | NUM_PINS | Software write that clears the flag |
| req | output | NUM_PINS | Registered request flags |

## Verification
The bench goes after the corners where a wrong design behaves differently. A sampler that runs on every clock would flag a fall during strobe-free cycles (R1) and would catch short pulses that should be missed (R11). A design that clears level flags on acknowledge would drop a request that is still held low (R4, R5). A design that resets the previous sample to 0, or that has the wrong number of synchronizer stages, would flag too early or too late (R9, R10). Precedence bugs are targeted by driving a hardware fall together with a software clear, and software set together with clear or acknowledge (R3, R7, R8). Long random runs with mixed modes compare every cycle against a reference model.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {STAGES{RST_VAL}};
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/irq_pin_channel.sv
module irq_pin_channel
  import irq_cap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic synced_i,
  input  logic stb_i,
  input  logic mode_i,
  input  logic ack_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic req_o
);
  trig_e trig;
  logic  samp_q;
  logic  flag_q, flag_d;
  logic  fall;

  assign trig = trig_e'(mode_i);
  assign fall = stb_i & samp_q & ~synced_i;

  always_comb begin
    flag_d = flag_q;
    if (trig == TRIG_EDGE) begin
      if (fall)          flag_d = 1'b1;
      else if (sw_set_i) flag_d = 1'b1;
      else if (sw_clr_i) flag_d = 1'b0;
      else if (ack_i)    flag_d = 1'b0;
    end else begin
      if (stb_i)         flag_d = ~synced_i;
      else if (sw_set_i) flag_d = 1'b1;
      else if (sw_clr_i) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (stb_i) samp_q <= synced_i;
      flag_q <= flag_d;
    end
  end

  assign req_o = flag_q;

  // R1
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb_i && !ack_i && !sw_set_i && !sw_clr_i) |=> $stable(req_o));
  // R3
  edge_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i && ack_i && !stb_i && !sw_set_i) |=> !req_o);
  // R4
  level_track_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && stb_i) |=> (req_o == !$past(synced_i)));
  // R4
  level_ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && !stb_i && ack_i && !sw_set_i && !sw_clr_i) |=> $stable(req_o));
  // R8
  hw_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i && stb_i && samp_q && !synced_i && sw_clr_i) |=> req_o);
endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture #(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_n,
  input  logic                mcyc_stb,
  input  logic [NUM_PINS-1:0] mode_edge,
  input  logic [NUM_PINS-1:0] ack,
  input  logic [NUM_PINS-1:0] sw_set,
  input  logic [NUM_PINS-1:0] sw_clr,
  output logic [NUM_PINS-1:0] req
);
  logic [NUM_PINS-1:0] synced;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (pin_n[i]),
      .q_o (synced[i])
    );
    irq_pin_channel u_chan (
      .clk      (clk),
      .rst      (rst),
      .synced_i (synced[i]),
      .stb_i    (mcyc_stb),
      .mode_i   (mode_edge[i]),
      .ack_i    (ack[i]),
      .sw_set_i (sw_set[i]),
      .sw_clr_i (sw_clr[i]),
      .req_o    (req[i])
    );
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk) rst |=> (req == '0));
endmodule

// File: tb/ext_irq_capture_tb.sv
`timescale 1ns/1ps
module ext_irq_capture_tb;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_n = '1;
  logic         mcyc_stb = 1'b0;
  logic [N-1:0] mode_edge = '1;
  logic [N-1:0] ack = '0;
  logic [N-1:0] sw_set = '0;
  logic [N-1:0] sw_clr = '0;
  logic [N-1:0] req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [N-1:0] m_sy1, m_sy2, m_samp, m_flag;

  always #2.5 clk = ~clk;

  ext_irq_capture #(.NUM_PINS(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .pin_n(pin_n), .mcyc_stb(mcyc_stb),
    .mode_edge(mode_edge), .ack(ack), .sw_set(sw_set), .sw_clr(sw_clr),
    .req(req)
  );

  function automatic logic next_flag(logic edge_m, logic stb, logic samp,
                                     logic s, logic a, logic st, logic cl,
                                     logic cur);
    if (edge_m) begin
      if (stb && samp && !s) return 1'b1;
      if (st) return 1'b1;
      if (cl) return 1'b0;
      if (a)  return 1'b0;
      return cur;
    end
    if (stb) return !s;
    if (st)  return 1'b1;
    if (cl)  return 1'b0;
    return cur;
  endfunction

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: req got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sy1 = '1; m_sy2 = '1; m_samp = '1; m_flag = '0;
  endtask

  task automatic tick(string tag);
    logic [N-1:0] nf;
    for (int i = 0; i < N; i++)
      nf[i] = next_flag(mode_edge[i], mcyc_stb, m_samp[i], m_sy2[i],
                        ack[i], sw_set[i], sw_clr[i], m_flag[i]);
    if (mcyc_stb) m_samp = m_sy2;
    m_sy2 = m_sy1;
    m_sy1 = pin_n;
    m_flag = nf;
    @(posedge clk);
    @(negedge clk);
    chk(tag, req, m_flag);
  endtask

  task automatic idle();
    mcyc_stb = 1'b0; ack = '0; sw_set = '0; sw_clr = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7211));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9", req, '0);
    mcyc_stb = 1'b1;
    repeat (6) tick("R9");
    chk("R9", req, '0);

    // R1: fall with no strobe is not seen
    idle(); pin_n[0] = 1'b0;
    repeat (6) tick("R1");
    chk("R1", req, 2'b00);
    pin_n[0] = 1'b1;
    repeat (6) tick("R1");
    mcyc_stb = 1'b1;
    repeat (3) tick("R1");
    chk("R1", req, 2'b00);

    // R10 / R2: latency with strobe every clock
    pin_n[0] = 1'b0;
    tick("R10"); tick("R10");
    chk("R10", req, 2'b00);
    tick("R2");
    chk("R2", req, 2'b01);

    // R3: ack clears edge flag
    idle(); ack[0] = 1'b1;
    tick("R3");
    chk("R3", req, 2'b00);
    idle(); pin_n[0] = 1'b1;
    mcyc_stb = 1'b1; repeat (4) tick("R3");

    // R4 / R5 / R6: pin1 level, pin0 edge
    mode_edge = 2'b01;
    pin_n[1] = 1'b0;
    repeat (4) tick("R6");
    chk("R4", req, 2'b10);
    idle(); ack[1] = 1'b1;
    tick("R4");
    chk("R4", req, 2'b10);
    idle(); mcyc_stb = 1'b1;
    repeat (3) tick("R5");
    chk("R5", req, 2'b10);
    pin_n[1] = 1'b1;
    repeat (4) tick("R4");
    chk("R4", req, 2'b00);

    // R7 software writes
    mode_edge = 2'b11;
    idle(); sw_set = 2'b11;
    tick("R7");
    chk("R7", req, 2'b11);
    idle(); sw_clr = 2'b01;
    tick("R7");
    chk("R7", req, 2'b10);
    idle(); sw_set = 2'b01; sw_clr = 2'b11;
    tick("R7");
    chk("R7", req, 2'b01);
    idle(); sw_clr = 2'b11;
    tick("R7");

    // R8: hardware fall beats software clear
    mcyc_stb = 1'b1; pin_n[1] = 1'b0;
    tick("R8"); tick("R8");
    sw_clr = 2'b10;
    tick("R8");
    chk("R8", req, 2'b10);
    idle(); sw_clr = 2'b10; pin_n[1] = 1'b1;
    tick("R8");
    idle(); mcyc_stb = 1'b1; repeat (4) tick("R8");

    // R11: short pulse between strobes
    idle(); pin_n[0] = 1'b0;
    tick("R11");
    pin_n[0] = 1'b1;
    repeat (4) tick("R11");
    mcyc_stb = 1'b1;
    repeat (3) tick("R11");
    chk("R11", req, 2'b00);

    // random mix against the model (R1 R2 R3 R4 R6 R7)
    for (int k = 0; k < 4000; k++) begin
      mcyc_stb = (k % 4) == 0;
      if (($urandom % 200) == 0) mode_edge = N'($urandom);
      for (int i = 0; i < N; i++) begin
        if (($urandom % 6) == 0) pin_n[i] = ~pin_n[i];
        ack[i]    = ($urandom % 10) == 0;
        sw_set[i] = ($urandom % 40) == 0;
        sw_clr[i] = ($urandom % 30) == 0;
      end
      tick("R2 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule